// File: doc/BRIEF.md
# Transmit Packet Framing Source

This block sits between a user-side packet producer and the 64-bit transmit packet port of a PCI Express endpoint. Words arrive one at a time, each tagged with a traffic class (non-posted, posted or completion), a last-word flag, a half-word flag that says only the upper 32 bits of the final word carry data, and a discontinue flag. Each class has its own small queue. The block picks one class at a time and streams that class's packet to the endpoint over an active-low valid/ready handshake. It marks the first beat as start of frame and the final beat as end of frame, and it encodes how much of the final beat is valid.

A packet starts only if the endpoint reports buffer space for its class in the cycle its first beat is shown. Classes share the port in round-robin order. Completions give way to the other two classes while the endpoint's completion look-ahead flag is low. A packet that has started is never interleaved with another. It can be cut short by a discontinue flag on any word after the first. The cut beat carries both end of frame and discontinue, and the rest of that packet is dropped from its queue.

Top module: `tlp_tx_framer`

## Requirements
- R1: After reset, tx_src_rdy_n, tx_sof_n, tx_eof_n and tx_src_dsc_n are all 1, every class queue is empty, and in_ready is 1 for class codes 0, 1 and 2.
- R2: A beat transfers only on a cycle where tx_src_rdy_n and tx_dst_rdy_n are both 0. The words of a packet leave in the order they were queued. tx_sof_n is 0 on the first beat only and tx_eof_n is 0 on the last beat only, and both are meaningful only while tx_src_rdy_n is 0.
- R3: tx_rem_n is 8'h00 on every beat except a final beat whose word has the half flag set, which carries 8'h0F (only bits 63:32 valid).
- R4: Packets stream back to back. The start-of-frame beat of the next packet can transfer on the cycle right after the end-of-frame beat of the previous one, and consecutive beats of one queued packet transfer on consecutive cycles while the endpoint is ready.
- R5: in_class codes are 0 non-posted, 1 posted, 2 completion. Code 3 is never accepted (in_ready is 0). tx_buf_av bit 0 is non-posted, bit 1 posted and bit 2 completion, and a 1 means space. No packet of a class starts while its bit is 0.
- R6: Among eligible classes the next packet is chosen round-robin, starting after the class of the most recently started packet. After reset the search order is non-posted, posted, completion.
- R7: While tx_buf_av bit 3 (completion look-ahead) is 0, a pending completion is passed over whenever a non-posted or posted packet is eligible. It is still sent when it is the only eligible packet.
- R8: Once a packet has started, only words of that packet are shown until its end of frame. If its queue runs dry mid-packet, tx_src_rdy_n goes to 1 rather than another class starting.
- R9: A word with the discontinue flag that is not the first word of its packet is sent with tx_eof_n and tx_src_dsc_n both 0. The remaining words of that packet, up to its last-flagged word, are dropped and never transferred.
- R10: A discontinue flag on the first word of a packet has no effect: tx_src_dsc_n stays 1 and the packet is sent whole.
- R11: While the endpoint stalls a started packet (tx_dst_rdy_n at 1), the shown beat holds: tx_src_rdy_n stays 0 and tx_data and the framing flags do not change.
- R12: in_ready for a class is 0 while that class's queue holds DEPTH words, while other classes still accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Queue of in_class can take a word |
| in_class | input | 2 | Traffic class of the input word |
| in_data | input | 64 | Input word data |
| in_last | input | 1 | Word is the last of its packet |
| in_half | input | 1 | Only bits 63:32 of this last word are valid |
| in_disc | input | 1 | Cut the packet at this word |
| tx_data | output | 64 | Beat data to the endpoint |
| tx_rem_n | output | 8 | Remainder code of the final beat |
| tx_sof_n | output | 1 | Start of frame, active low |
| tx_eof_n | output | 1 | End of frame, active low |
| tx_src_rdy_n | output | 1 | Beat valid, active low |
| tx_src_dsc_n | output | 1 | Discontinue, active low |
| tx_dst_rdy_n | input | 1 | Endpoint ready, active low |
| tx_buf_av | input | 4 | Per-class buffer space and completion look-ahead |

## Verification
Beats are formed combinationally from the queue heads. A word accepted at one rising edge can be shown during the next cycle and transfer at the following edge. The framing flags and remainder code belong to the same cycle as their beat. The class choice reacts to tx_buf_av in the same cycle, with no extra register. The bench therefore samples at the falling edge and records only cycles where both ready signals are low, stamping each with a cycle number. Checks compare beat contents, flags and class order by beat index, and compare back-to-back timing by the difference of the cycle stamps. Stall and gating checks look at the outputs in the falling-edge window of specific cycles.

// File: rtl/tlp_tx_pkg.sv
package tlp_tx_pkg;

    localparam int DATA_W      = 64;
    localparam int REM_W       = 8;
    localparam int NUM_CLASSES = 3;
    localparam int CLS_W       = 2;
    localparam int AV_W        = NUM_CLASSES + 1;
    localparam int LOOKAHEAD_BIT = NUM_CLASSES;

    typedef enum logic [CLS_W-1:0] {
        CLS_NP   = 2'd0,
        CLS_P    = 2'd1,
        CLS_CPL  = 2'd2,
        CLS_NONE = 2'd3
    } tlp_class_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              last;
        logic              half;
        logic              disc;
    } tx_word_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BODY  = 2'd1,
        ST_FLUSH = 2'd2
    } frame_state_e;

    localparam logic [REM_W-1:0] REM_FULL  = 8'h00;
    localparam logic [REM_W-1:0] REM_UPPER = 8'h0F;

    // Remainder code for a final beat
    function automatic logic [REM_W-1:0] rem_code(input logic half);
        return half ? REM_UPPER : REM_FULL;
    endfunction

    // Class index that follows c in round-robin order, offset by k
    function automatic logic [CLS_W-1:0] rr_class(input logic [CLS_W-1:0] c, input int k);
        int t;
        t = int'(c) + k;
        while (t >= NUM_CLASSES) t = t - NUM_CLASSES;
        return CLS_W'(t);
    endfunction

endpackage

// File: rtl/tx_class_queue.sv
module tx_class_queue
    import tlp_tx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  tx_word_t wdata,
    input  logic     pop,
    output tx_word_t head,
    output logic     empty,
    output logic     full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);

    tx_word_t        mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic [CW-1:0]   count;
    logic            do_push;
    logic            do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_MAX);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/tx_class_arbiter.sv
module tx_class_arbiter
    import tlp_tx_pkg::*;
(
    input  logic [NUM_CLASSES-1:0] pending,
    input  logic [AV_W-1:0]        buf_av,
    input  logic [CLS_W-1:0]       last_grant,
    output logic [CLS_W-1:0]       pick,
    output logic                   pick_valid
);
    logic [NUM_CLASSES-1:0] elig;
    logic                   found;
    logic [CLS_W-1:0]       cand;

    always_comb begin
        elig = pending & buf_av[NUM_CLASSES-1:0];
        // completions step aside while look-ahead is low and others can go
        if (!buf_av[LOOKAHEAD_BIT] && (elig[CLS_NP] || elig[CLS_P])) begin
            elig[CLS_CPL] = 1'b0;
        end
        pick_valid = |elig;
        pick       = last_grant;
        found      = 1'b0;
        for (int k = 1; k <= NUM_CLASSES; k++) begin
            cand = rr_class(last_grant, k);
            if (!found && elig[cand]) begin
                pick  = cand;
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tlp_tx_framer.sv
module tlp_tx_framer
    import tlp_tx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CLS_W-1:0]  in_class,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_half,
    input  logic              in_disc,
    output logic [DATA_W-1:0] tx_data,
    output logic [REM_W-1:0]  tx_rem_n,
    output logic              tx_sof_n,
    output logic              tx_eof_n,
    output logic              tx_src_rdy_n,
    output logic              tx_src_dsc_n,
    input  logic              tx_dst_rdy_n,
    input  logic [AV_W-1:0]   tx_buf_av
);
    localparam int SLOTS = 1 << CLS_W;

    tx_word_t               in_word;
    tx_word_t               heads    [SLOTS];
    logic [SLOTS-1:0]       empty_ext;
    logic [SLOTS-1:0]       full_ext;
    logic [NUM_CLASSES-1:0] push_vec;
    logic [NUM_CLASSES-1:0] pop_vec;

    frame_state_e           state;
    logic [CLS_W-1:0]       cur;
    logic [CLS_W-1:0]       last_grant;

    logic [CLS_W-1:0]       pick;
    logic                   pick_valid;
    logic [CLS_W-1:0]       sel;
    tx_word_t               head;
    logic                   present;
    logic                   is_sof;
    logic                   is_dsc;
    logic                   is_eof;
    logic                   xfer;

    assign in_word  = '{data: in_data, last: in_last, half: in_half, disc: in_disc};
    assign in_ready = (in_class != CLS_NONE) && !full_ext[in_class];

    // one queue per traffic class
    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_queue
        assign push_vec[c] = in_valid && in_ready && (in_class == CLS_W'(c));
        tx_class_queue #(.DEPTH(DEPTH)) u_queue (
            .clk   (clk),
            .rst   (rst),
            .push  (push_vec[c]),
            .wdata (in_word),
            .pop   (pop_vec[c]),
            .head  (heads[c]),
            .empty (empty_ext[c]),
            .full  (full_ext[c])
        );
        assign pop_vec[c] = (xfer && (sel == CLS_W'(c)))
                         || ((state == ST_FLUSH) && (cur == CLS_W'(c)) && !empty_ext[c]);
    end

    for (genvar s = NUM_CLASSES; s < SLOTS; s++) begin : g_unused_slot
        assign heads[s]     = '0;
        assign empty_ext[s] = 1'b1;
        assign full_ext[s]  = 1'b1;
    end

    tx_class_arbiter u_arb (
        .pending    (~empty_ext[NUM_CLASSES-1:0]),
        .buf_av     (tx_buf_av),
        .last_grant (last_grant),
        .pick       (pick),
        .pick_valid (pick_valid)
    );

    // beat selection
    always_comb begin
        case (state)
            ST_IDLE: begin
                sel     = pick;
                present = pick_valid;
            end
            ST_BODY: begin
                sel     = cur;
                present = !empty_ext[cur];
            end
            default: begin
                sel     = cur;
                present = 1'b0;
            end
        endcase
        head   = heads[sel];
        is_sof = present && (state == ST_IDLE);
        is_dsc = present && (state == ST_BODY) && head.disc;
        is_eof = present && (head.last || is_dsc);
        xfer   = present && !tx_dst_rdy_n;
    end

    assign tx_data      = head.data;
    assign tx_src_rdy_n = !present;
    assign tx_sof_n     = !is_sof;
    assign tx_eof_n     = !is_eof;
    assign tx_src_dsc_n = !is_dsc;
    assign tx_rem_n     = (is_eof && head.last) ? rem_code(head.half) : REM_FULL;

    // framing state
    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cur        <= CLS_NP;
            last_grant <= CLS_CPL;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (xfer) begin
                        cur        <= sel;
                        last_grant <= sel;
                        state      <= head.last ? ST_IDLE : ST_BODY;
                    end
                end
                ST_BODY: begin
                    if (xfer && is_eof) begin
                        state <= head.last ? ST_IDLE : ST_FLUSH;
                    end
                end
                ST_FLUSH: begin
                    if (!empty_ext[cur] && head.last) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tlp_tx_framer_checker.sv
module tlp_tx_framer_checker
    import tlp_tx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] tx_data,
    input logic [REM_W-1:0]  tx_rem_n,
    input logic              tx_sof_n,
    input logic              tx_eof_n,
    input logic              tx_src_rdy_n,
    input logic              tx_src_dsc_n,
    input logic              tx_dst_rdy_n,
    input logic [AV_W-1:0]   tx_buf_av
);
    logic pkt_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_open <= 1'b0;
        end else if (!tx_src_rdy_n && !tx_dst_rdy_n) begin
            pkt_open <= tx_eof_n;
        end
    end

    // R2: framing flags only with a valid beat
    assert_flags_need_valid_R2: assert property (@(posedge clk) disable iff (rst)
        (!tx_sof_n || !tx_eof_n || !tx_src_dsc_n) |-> !tx_src_rdy_n);

    // R3: remainder code only on the final beat
    assert_rem_only_on_eof_R3: assert property (@(posedge clk) disable iff (rst)
        (!tx_src_rdy_n && tx_eof_n) |-> (tx_rem_n == REM_FULL));

    // R5: a start needs some class with space
    assert_start_needs_space_R5: assert property (@(posedge clk) disable iff (rst)
        (!tx_src_rdy_n && !tx_sof_n) |-> (|tx_buf_av[NUM_CLASSES-1:0]));

    // R8: no new start inside an open packet
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (pkt_open && !tx_src_rdy_n) |-> tx_sof_n);

    // R2: first beat of every packet is marked
    assert_first_beat_marked_R2: assert property (@(posedge clk) disable iff (rst)
        (!pkt_open && !tx_src_rdy_n) |-> !tx_sof_n);

    // R9: discontinue closes the frame
    assert_dsc_ends_frame_R9: assert property (@(posedge clk) disable iff (rst)
        !tx_src_dsc_n |-> !tx_eof_n);

    // R10: never discontinue on a start beat
    assert_no_dsc_on_sof_R10: assert property (@(posedge clk) disable iff (rst)
        !tx_src_dsc_n |-> tx_sof_n);

    // R11: a stalled beat inside a packet holds
    assert_stall_holds_R11: assert property (@(posedge clk) disable iff (rst)
        (pkt_open && !tx_src_rdy_n && tx_dst_rdy_n) |=>
        (!tx_src_rdy_n && $stable(tx_data) && $stable(tx_eof_n) && $stable(tx_src_dsc_n)));

endmodule

bind tlp_tx_framer tlp_tx_framer_checker u_checker (.*);

// File: tb/tlp_tx_framer_test.sv
module tlp_tx_framer_test;
    import tlp_tx_pkg::*;

    localparam int DEPTH = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid;
    logic              in_ready;
    logic [1:0]        in_class;
    logic [63:0]       in_data;
    logic              in_last;
    logic              in_half;
    logic              in_disc;
    logic [63:0]       tx_data;
    logic [7:0]        tx_rem_n;
    logic              tx_sof_n;
    logic              tx_eof_n;
    logic              tx_src_rdy_n;
    logic              tx_src_dsc_n;
    logic              tx_dst_rdy_n;
    logic [3:0]        tx_buf_av;

    always #5 clk = ~clk;

    tlp_tx_framer #(.DEPTH(DEPTH)) uut (.*);

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int ncol = 0;
    logic [63:0] cdata [64];
    logic        csof  [64];
    logic        ceof  [64];
    logic        cdsc  [64];
    logic [7:0]  crem  [64];
    int          ccyc  [64];

    always @(posedge clk) cyc = cyc + 1;

    always @(negedge clk) begin
        if (!rst && !tx_src_rdy_n && !tx_dst_rdy_n && ncol < 64) begin
            cdata[ncol] = tx_data;
            csof[ncol]  = tx_sof_n;
            ceof[ncol]  = tx_eof_n;
            cdsc[ncol]  = tx_src_dsc_n;
            crem[ncol]  = tx_rem_n;
            ccyc[ncol]  = cyc;
            ncol = ncol + 1;
        end
    end

    function automatic logic [63:0] mk(input int cls, input int id, input int idx);
        return {8'hA5, 6'd0, 2'(cls), 16'h0000, 8'(id), 16'h0000, 8'(idx)};
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input int cls, input logic [63:0] d, input logic l, input logic h, input logic dc);
        in_valid = 1'b1;
        in_class = 2'(cls);
        in_data  = d;
        in_last  = l;
        in_half  = h;
        in_disc  = dc;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        step();
        in_valid = 1'b0;
    endtask

    task automatic push_pkt(input int cls, input int id, input int len, input logic h, input int disc_idx);
        for (int i = 0; i < len; i++) begin
            push(cls, mk(cls, id, i), (i == len - 1), (i == len - 1) && h, (i == disc_idx));
        end
    endtask

    task automatic wait_beats(input int n);
        for (int i = 0; i < 300 && ncol < n; i++) step();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        ncol = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        in_valid = 0; in_class = 0; in_data = 0; in_last = 0; in_half = 0; in_disc = 0;
        tx_dst_rdy_n = 1'b0;
        tx_buf_av = 4'hF;
        do_reset();

        // R1: reset state
        @(negedge clk);
        chk("R1", "src_rdy_n", tx_src_rdy_n, 1);
        chk("R1", "sof_n", tx_sof_n, 1);
        chk("R1", "eof_n", tx_eof_n, 1);
        chk("R1", "dsc_n", tx_src_dsc_n, 1);
        for (int c = 0; c < 3; c++) begin
            in_class = 2'(c);
            #1;
            chk("R1", "in_ready", in_ready, 1);
        end
        step();

        // R2: three-beat packet in order with framing
        ncol = 0;
        push_pkt(0, 1, 3, 1'b0, -1);
        wait_beats(3);
        chk("R2", "beats", ncol, 3);
        for (int i = 0; i < 3; i++) begin
            chk("R2", "data", cdata[i], mk(0, 1, i));
            chk("R2", "sof_n", csof[i], (i == 0) ? 0 : 1);
            chk("R2", "eof_n", ceof[i], (i == 2) ? 0 : 1);
            chk("R3", "rem full", crem[i], 8'h00);
        end

        // R3: upper-half final word
        ncol = 0;
        push_pkt(1, 2, 2, 1'b1, -1);
        wait_beats(2);
        chk("R3", "rem first", crem[0], 8'h00);
        chk("R3", "rem upper", crem[1], 8'h0F);
        chk("R3", "eof_n", ceof[1], 0);

        // R4: back to back packets
        tx_dst_rdy_n = 1'b1;
        push_pkt(1, 3, 2, 1'b0, -1);
        push_pkt(1, 4, 1, 1'b0, -1);
        ncol = 0;
        tx_dst_rdy_n = 1'b0;
        wait_beats(3);
        chk("R4", "beat gap 0-1", ccyc[1] - ccyc[0], 1);
        chk("R4", "beat gap 1-2", ccyc[2] - ccyc[1], 1);
        chk("R4", "eof before", ceof[1], 0);
        chk("R4", "sof after", csof[2], 0);
        chk("R4", "second data", cdata[2], mk(1, 4, 0));

        // R5: gating on buffer space, class 3 refused
        tx_buf_av = 4'b1110;
        ncol = 0;
        push_pkt(0, 5, 1, 1'b0, -1);
        repeat (10) step();
        @(negedge clk);
        chk("R5", "gated beats", ncol, 0);
        chk("R5", "gated src_rdy_n", tx_src_rdy_n, 1);
        in_class = 2'd3;
        #1;
        chk("R5", "class3 in_ready", in_ready, 0);
        step();
        tx_buf_av = 4'hF;
        wait_beats(1);
        chk("R5", "released data", cdata[0], mk(0, 5, 0));

        // R12: full queue back-pressure
        tx_dst_rdy_n = 1'b1;
        push_pkt(0, 6, DEPTH, 1'b0, -1);
        in_class = 2'd0;
        #1;
        chk("R12", "full in_ready", in_ready, 0);
        in_class = 2'd1;
        #1;
        chk("R12", "other in_ready", in_ready, 1);
        ncol = 0;
        step();
        tx_dst_rdy_n = 1'b0;
        wait_beats(DEPTH);
        chk("R12", "drained", ncol, DEPTH);
        chk("R12", "last data", cdata[DEPTH-1], mk(0, 6, DEPTH - 1));

        // R6: round robin after reset
        do_reset();
        tx_dst_rdy_n = 1'b1;
        push_pkt(2, 10, 1, 1'b0, -1);
        push_pkt(1, 11, 1, 1'b0, -1);
        push_pkt(0, 12, 1, 1'b0, -1);
        ncol = 0;
        tx_dst_rdy_n = 1'b0;
        wait_beats(3);
        chk("R6", "order 0", cdata[0][49:48], 0);
        chk("R6", "order 1", cdata[1][49:48], 1);
        chk("R6", "order 2", cdata[2][49:48], 2);

        // R6: pointer continues after last started class
        do_reset();
        push_pkt(1, 20, 1, 1'b0, -1);
        wait_beats(1);
        tx_dst_rdy_n = 1'b1;
        push_pkt(0, 21, 1, 1'b0, -1);
        push_pkt(2, 22, 1, 1'b0, -1);
        ncol = 0;
        tx_dst_rdy_n = 1'b0;
        wait_beats(2);
        chk("R6", "after posted 0", cdata[0][49:48], 2);
        chk("R6", "after posted 1", cdata[1][49:48], 0);

        // R7: look-ahead low skips completion
        do_reset();
        push_pkt(1, 30, 1, 1'b0, -1);
        wait_beats(1);
        tx_dst_rdy_n = 1'b1;
        tx_buf_av = 4'b0111;
        push_pkt(0, 31, 1, 1'b0, -1);
        push_pkt(2, 32, 1, 1'b0, -1);
        ncol = 0;
        tx_dst_rdy_n = 1'b0;
        wait_beats(2);
        chk("R7", "skip cpl", cdata[0][49:48], 0);
        chk("R7", "cpl alone", cdata[1][49:48], 2);
        tx_buf_av = 4'hF;

        // R8: no interleave while a packet waits for words
        tx_dst_rdy_n = 1'b1;
        push(0, mk(0, 40, 0), 1'b0, 1'b0, 1'b0);
        push_pkt(1, 41, 1, 1'b0, -1);
        ncol = 0;
        tx_dst_rdy_n = 1'b0;
        wait_beats(1);
        repeat (5) step();
        @(negedge clk);
        chk("R8", "held beats", ncol, 1);
        chk("R8", "gap src_rdy_n", tx_src_rdy_n, 1);
        step();
        push(0, mk(0, 40, 1), 1'b1, 1'b0, 1'b0);
        wait_beats(3);
        chk("R8", "tail data", cdata[1], mk(0, 40, 1));
        chk("R8", "tail eof_n", ceof[1], 0);
        chk("R8", "next class", cdata[2], mk(1, 41, 0));

        // R9: discontinue mid packet, rest flushed
        ncol = 0;
        push_pkt(0, 50, 4, 1'b0, 1);
        push_pkt(0, 51, 1, 1'b0, -1);
        wait_beats(3);
        repeat (5) step();
        chk("R9", "beats", ncol, 3);
        chk("R9", "cut eof_n", ceof[1], 0);
        chk("R9", "cut dsc_n", cdsc[1], 0);
        chk("R9", "next pkt", cdata[2], mk(0, 51, 0));
        chk("R9", "next sof_n", csof[2], 0);

        // R10: discontinue on first word ignored
        ncol = 0;
        push_pkt(0, 60, 2, 1'b0, 0);
        wait_beats(2);
        repeat (3) step();
        chk("R10", "beats", ncol, 2);
        chk("R10", "dsc_n first", cdsc[0], 1);
        chk("R10", "dsc_n last", cdsc[1], 1);
        chk("R10", "eof_n last", ceof[1], 0);

        // R11: stall mid packet holds the beat
        tx_dst_rdy_n = 1'b1;
        push_pkt(1, 70, 3, 1'b0, -1);
        ncol = 0;
        tx_dst_rdy_n = 1'b0;
        step();
        tx_dst_rdy_n = 1'b1;
        repeat (4) step();
        @(negedge clk);
        chk("R11", "one beat", ncol, 1);
        chk("R11", "src_rdy_n", tx_src_rdy_n, 0);
        chk("R11", "sof_n", tx_sof_n, 1);
        chk("R11", "held data", tx_data, mk(1, 70, 1));
        step();
        tx_dst_rdy_n = 1'b0;
        wait_beats(3);
        chk("R11", "beat1", cdata[1], mk(1, 70, 1));
        chk("R11", "beat2", cdata[2], mk(1, 70, 2));
        chk("R11", "beat2 eof_n", ceof[2], 0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule